// File: doc/BRIEF.md
# Modem Control Register Loopback Router

This block is the digital control side of a dial-up modem data path. A small bus write port loads four 8-bit control registers. Their contents set how the serial transmit input and receive output connect to the modulator input and the demodulator output. The block also selects the source for the clock output pin, reports the selected line rate, and drives two line controls: a line-drive enable and a receive carrier band select.

Four routings are available: normal operation, analog loopback, remote digital loopback and local digital loopback. Writing the soft-reset bit returns the block to its power-down state. All control bits clear at that point except one protected bit. The analog modulator, demodulator, carrier generation and crystal oscillator sit outside the block, and each one appears only as a plain digital port.

Register map (address, field bits): 0 = MODE {[0] answer, [1] tx_en, [3:2] mtype, [4] mopt}; 1 = TEST {[1:0] loop, [2] srst, [3] clk16}; 2 = AUX {[2] protected}; 3 = TONE {[2] tone_on}. Any bits not named here are plain storage. The mtype field is coded 00 DPSK, 01 QAM, 1x FSK. The loop field is coded 00 normal, 01 analog, 10 remote digital, 11 local digital.

Top module: `mdm_ctl_router`

## Requirements
- R1: On a rising clock edge with cs_i and we_i both high, the register at addr_i (0 to 3) takes wdata_i. rdata_o returns the contents at addr_i combinationally. Addresses 4 to 7 read as 0, and writes to them change no register.
- R2: When loop = 00, rxd_o carries demod_i and mod_o carries txd_i, each with one register stage.
- R3: When loop = 01, rxd_o carries demod_i, mod_o carries txd_i and line_loop_o is 1. rx_band_o then equals the transmit band (the answer bit); in every other mode it is the inverse of the answer bit.
- R4: When loop = 10, rxd_o is held at mark (1), mod_o carries demod_i one cycle late, and txd_i has no effect on either output.
- R5: When loop = 11, rxd_o carries txd_i one cycle late and mod_o keeps carrying txd_i, so a data carrier stays on the line.
- R6: line_drive_o is low only when both tx_en and tone_on are low. This includes analog loopback.
- R7: A write to address 1 with bit 2 set clears MODE, TEST and TONE, and clears every AUX bit except AUX[2], which holds its value. The srst bit reads back as 0.
- R8: clk_pin_o follows xtal_i unless clk16 = 1 and mtype is DPSK or QAM, in which case it follows rate16_i. An FSK mtype overrides clk16 = 1, and after a soft reset the pin returns to xtal_i.
- R9: rate_o encodes the line rate as 0 = 1200, 1 = 600, 2 = 2400, 3 = Bell 103 FSK, 4 = V.21 FSK. With mopt = 0: DPSK gives 0, QAM gives 2 and FSK gives 3. With mopt = 1: DPSK gives 1, QAM gives 2 and FSK gives 4.
- R10: After reset all registers read 0, rxd_o and mod_o are 1, line_loop_o and line_drive_o are 0, and clk_pin_o follows xtal_i.
- R11: A routing change takes effect at the same edge that writes the TEST register. rxd_o and mod_o are register outputs, so they change only at clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cs_i | input | 1 | Register port select |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i |
| txd_i | input | 1 | Serial transmit data from the host |
| rxd_o | output | 1 | Serial receive data to the host |
| demod_i | input | 1 | Demodulator data output |
| mod_o | output | 1 | Modulator data input |
| line_loop_o | output | 1 | Loop the line signal into the receiver |
| line_drive_o | output | 1 | Line output drive enable |
| rx_band_o | output | 1 | Receiver carrier band (1 = answer band) |
| xtal_i | input | 1 | Crystal clock echo source |
| rate16_i | input | 1 | 16x data-rate clock source |
| clk_pin_o | output | 1 | Clock output pin |
| rate_o | output | 3 | Selected line rate code |

## Verification
A single TEST write can change the loop field in the same cycle that new serial data is arriving on txd_i and demod_i. The bench therefore has to show that the first sampled bit after the edge already follows the new routing. A soft reset can also fall in the same cycle as a routing or clock-source change. In that case it must win, dropping the routing to normal and the clock pin to the crystal while AUX[2] is kept. Random writes with random serial data and rare srst bits provoke these collisions, and directed writes set up the same cases on purpose. A bench model, stepped once per edge, predicts every output, and the outputs are compared at the following falling edge.

// File: rtl/mdm_pkg.sv
`timescale 1ns/1ps
package mdm_pkg;
  localparam int DW   = 8;
  localparam int AW   = 3;
  localparam int NREG = 4;

  localparam logic [AW-1:0] A_MODE = 3'd0;
  localparam logic [AW-1:0] A_TEST = 3'd1;
  localparam logic [AW-1:0] A_AUX  = 3'd2;
  localparam logic [AW-1:0] A_TONE = 3'd3;

  localparam int B_ANS   = 0;
  localparam int B_TXEN  = 1;
  localparam int B_MTYP  = 2;
  localparam int B_MOPT  = 4;
  localparam int B_LOOP  = 0;
  localparam int B_SRST  = 2;
  localparam int B_CLK16 = 3;
  localparam int B_KEEP  = 2;
  localparam int B_TONE  = 2;

  typedef enum logic [1:0] {
    LB_NONE   = 2'd0,
    LB_ANALOG = 2'd1,
    LB_REMOTE = 2'd2,
    LB_LOCAL  = 2'd3
  } loop_e;

  typedef enum logic [1:0] {
    MT_DPSK = 2'd0,
    MT_QAM  = 2'd1,
    MT_FSK  = 2'd2,
    MT_FSK2 = 2'd3
  } mtype_e;

  typedef enum logic [2:0] {
    RT_1200 = 3'd0,
    RT_600  = 3'd1,
    RT_2400 = 3'd2,
    RT_B103 = 3'd3,
    RT_V21  = 3'd4
  } rate_e;
endpackage

// File: rtl/mdm_rst_sync.sv
`timescale 1ns/1ps
module mdm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_s_n = sync_q[STAGES-1];
endmodule

// File: rtl/mdm_regfile.sv
`timescale 1ns/1ps
module mdm_regfile
  import mdm_pkg::*;
#(
  parameter int RDW = DW,
  parameter int RAW = AW,
  parameter int RN  = NREG
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cs_i,
  input  logic           we_i,
  input  logic [RAW-1:0] addr_i,
  input  logic [RDW-1:0] wdata_i,
  output logic [RDW-1:0] rdata_o,
  output logic           answer_o,
  output logic           tx_en_o,
  output mtype_e         mtype_o,
  output logic           mopt_o,
  output loop_e          loop_o,
  output loop_e          loop_nxt_o,
  output logic           clk16_o,
  output logic           tone_on_o
);
  localparam int IW = $clog2(RN);

  logic [RDW-1:0] q [RN];
  logic [RDW-1:0] d [RN];
  logic [RN-1:0]  en;
  logic [RDW-1:0] keep [RN];
  logic           wr_hit;
  logic           srst_req;
  logic           addr_ok;

  // Protected-bit mask per register, built by generate.
  for (genvar g = 0; g < RN; g++) begin : g_keep
    if (g == int'(A_AUX)) begin : g_aux
      assign keep[g] = RDW'(1) << B_KEEP;
    end else begin : g_clr
      assign keep[g] = '0;
    end
  end

  always_comb begin
    wr_hit   = cs_i && we_i;
    addr_ok  = (addr_i < RAW'(RN));
    srst_req = wr_hit && (addr_i == A_TEST) && wdata_i[B_SRST];
    for (int i = 0; i < RN; i++) begin
      en[i] = srst_req || (wr_hit && addr_i == RAW'(i));
      if (srst_req)
        d[i] = q[i] & keep[i];
      else if (wr_hit && addr_i == RAW'(i))
        d[i] = wdata_i;
      else
        d[i] = q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < RN; i++) q[i] <= '0;
    end else begin
      for (int i = 0; i < RN; i++)
        if (en[i]) q[i] <= d[i];
    end
  end

  always_comb begin
    rdata_o = addr_ok ? q[addr_i[IW-1:0]] : '0;
  end

  assign answer_o   = q[A_MODE][B_ANS];
  assign tx_en_o    = q[A_MODE][B_TXEN];
  assign mtype_o    = mtype_e'(q[A_MODE][B_MTYP +: 2]);
  assign mopt_o     = q[A_MODE][B_MOPT];
  assign loop_o     = loop_e'(q[A_TEST][B_LOOP +: 2]);
  assign loop_nxt_o = loop_e'(d[A_TEST][B_LOOP +: 2]);
  assign clk16_o    = q[A_TEST][B_CLK16];
  assign tone_on_o  = q[A_TONE][B_TONE];

  // R7: soft reset clears all but the protected AUX bit
  a_r7_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_i && we_i && addr_i == A_TEST && wdata_i[B_SRST]) |=>
      (q[A_MODE] == '0 && q[A_TEST] == '0 && q[A_TONE] == '0 &&
       (q[A_AUX] & ~(RDW'(1) << B_KEEP)) == '0 &&
       q[A_AUX][B_KEEP] == $past(q[A_AUX][B_KEEP])));

  // R1: writes above the register range change nothing
  a_r1_high_addr_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_i && we_i && addr_i >= RAW'(RN)) |=>
      ($stable(q[A_MODE]) && $stable(q[A_TEST]) &&
       $stable(q[A_AUX]) && $stable(q[A_TONE])));

  // R7: srst bit never remains set in the register
  a_r7_srst_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !q[A_TEST][B_SRST]);
endmodule

// File: rtl/mdm_route.sv
`timescale 1ns/1ps
module mdm_route
  import mdm_pkg::*;
#(
  parameter logic IDLE_LVL = 1'b1
) (
  input  logic  clk,
  input  logic  rst_n,
  input  loop_e loop_nxt_i,
  input  logic  txd_i,
  input  logic  demod_i,
  output logic  rxd_o,
  output logic  mod_o
);
  logic rxd_d;
  logic mod_d;

  always_comb begin
    unique case (loop_nxt_i)
      LB_REMOTE: begin
        rxd_d = IDLE_LVL;
        mod_d = demod_i;
      end
      LB_LOCAL: begin
        rxd_d = txd_i;
        mod_d = txd_i;
      end
      default: begin
        rxd_d = demod_i;
        mod_d = txd_i;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxd_o <= IDLE_LVL;
      mod_o <= IDLE_LVL;
    end else begin
      rxd_o <= rxd_d;
      mod_o <= mod_d;
    end
  end

  // R4: remote loopback holds mark and loops the demodulator back
  a_r4_remote_mark: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(loop_nxt_i) == LB_REMOTE) |-> (rxd_o == IDLE_LVL && mod_o == $past(demod_i)));

  // R5: local loopback echoes host data and keeps the modulator fed
  a_r5_local_echo: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(loop_nxt_i) == LB_LOCAL) |-> (rxd_o == $past(txd_i) && mod_o == $past(txd_i)));

  // R2: normal and analog modes pass the demodulator to the host
  a_r2_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(loop_nxt_i) == LB_NONE || $past(loop_nxt_i) == LB_ANALOG) |->
      (rxd_o == $past(demod_i) && mod_o == $past(txd_i)));
endmodule

// File: rtl/mdm_clk_rate.sv
`timescale 1ns/1ps
module mdm_clk_rate
  import mdm_pkg::*;
(
  input  mtype_e     mtype_i,
  input  logic       mopt_i,
  input  logic       clk16_i,
  input  logic       xtal_i,
  input  logic       rate16_i,
  output logic       clk_pin_o,
  output logic [2:0] rate_o
);
  logic  is_fsk;
  rate_e rate_sel;

  always_comb begin
    is_fsk = (mtype_i == MT_FSK) || (mtype_i == MT_FSK2);
    unique case (mtype_i)
      MT_DPSK: rate_sel = mopt_i ? RT_600 : RT_1200;
      MT_QAM:  rate_sel = RT_2400;
      default: rate_sel = mopt_i ? RT_V21 : RT_B103;
    endcase
    clk_pin_o = (clk16_i && !is_fsk) ? rate16_i : xtal_i;
    rate_o    = rate_sel;
  end
endmodule

// File: rtl/mdm_ctl_router.sv
`timescale 1ns/1ps
module mdm_ctl_router
  import mdm_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic          txd_i,
  output logic          rxd_o,
  input  logic          demod_i,
  output logic          mod_o,
  output logic          line_loop_o,
  output logic          line_drive_o,
  output logic          rx_band_o,
  input  logic          xtal_i,
  input  logic          rate16_i,
  output logic          clk_pin_o,
  output logic [2:0]    rate_o
);
  logic   rst_s_n;
  logic   answer;
  logic   tx_en;
  mtype_e mtype;
  logic   mopt;
  loop_e  loop_q;
  loop_e  loop_nxt;
  logic   clk16;
  logic   tone_on;

  mdm_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_s_n (rst_s_n)
  );

  mdm_regfile #(.RDW(DW), .RAW(AW), .RN(NREG)) u_regs (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .cs_i       (cs_i),
    .we_i       (we_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .rdata_o    (rdata_o),
    .answer_o   (answer),
    .tx_en_o    (tx_en),
    .mtype_o    (mtype),
    .mopt_o     (mopt),
    .loop_o     (loop_q),
    .loop_nxt_o (loop_nxt),
    .clk16_o    (clk16),
    .tone_on_o  (tone_on)
  );

  mdm_route #(.IDLE_LVL(1'b1)) u_route (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .loop_nxt_i (loop_nxt),
    .txd_i      (txd_i),
    .demod_i    (demod_i),
    .rxd_o      (rxd_o),
    .mod_o      (mod_o)
  );

  mdm_clk_rate u_clk (
    .mtype_i   (mtype),
    .mopt_i    (mopt),
    .clk16_i   (clk16),
    .xtal_i    (xtal_i),
    .rate16_i  (rate16_i),
    .clk_pin_o (clk_pin_o),
    .rate_o    (rate_o)
  );

  always_comb begin
    line_loop_o  = (loop_q == LB_ANALOG);
    line_drive_o = tx_en || tone_on;
    rx_band_o    = line_loop_o ? answer : !answer;
  end

  // R8: FSK keeps the crystal echo on the clock pin
  a_r8_fsk_crystal: assert property (@(posedge clk) disable iff (!rst_s_n)
    (mtype == MT_FSK || mtype == MT_FSK2) |-> (clk_pin_o == xtal_i));

  // R8: after a soft reset the clock pin echoes the crystal
  a_r8_reset_clock: assert property (@(posedge clk) disable iff (!rst_s_n)
    (cs_i && we_i && addr_i == A_TEST && wdata_i[B_SRST]) |=> (clk_pin_o == xtal_i));

  // R6: squelch only when both drive sources are off
  a_r6_squelch: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!line_drive_o) |-> (!tx_en && !tone_on));

  // R3: analog loopback receives on the transmit band
  a_r3_band: assert property (@(posedge clk) disable iff (!rst_s_n)
    line_loop_o |-> (rx_band_o == answer));
endmodule

// File: tb/mdm_ctl_router_tb_top.sv
`timescale 1ns/1ps
module mdm_ctl_router_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cs_i, we_i;
  logic [2:0] addr_i;
  logic [7:0] wdata_i;
  logic [7:0] rdata_o;
  logic       txd_i, rxd_o, demod_i, mod_o;
  logic       line_loop_o, line_drive_o, rx_band_o;
  logic       xtal_i, rate16_i, clk_pin_o;
  logic [2:0] rate_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [7:0] m_reg [4];
  logic       m_rxd, m_mod;

  always #4 clk = ~clk;

  mdm_ctl_router dut_i (
    .clk(clk), .rst_n(rst_n), .cs_i(cs_i), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .txd_i(txd_i), .rxd_o(rxd_o),
    .demod_i(demod_i), .mod_o(mod_o), .line_loop_o(line_loop_o),
    .line_drive_o(line_drive_o), .rx_band_o(rx_band_o), .xtal_i(xtal_i),
    .rate16_i(rate16_i), .clk_pin_o(clk_pin_o), .rate_o(rate_o)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [2:0] exp_rate(input logic [1:0] mt, input logic mo);
    if (mt == 2'd0) return mo ? 3'd1 : 3'd0;
    if (mt == 2'd1) return 3'd2;
    return mo ? 3'd4 : 3'd3;
  endfunction

  function automatic logic exp_clk(input logic [7:0] mode, input logic [7:0] test,
                                   input logic xt, input logic r16);
    if (test[3] && !mode[3]) return r16;
    return xt;
  endfunction

  task automatic compare_all();
    logic [1:0] lp;
    lp = m_reg[1][1:0];
    chk("R1 rdata", rdata_o, (addr_i < 3'd4) ? m_reg[addr_i[1:0]] : 8'h00);
    chk("R11 rxd routing", {7'd0, rxd_o}, {7'd0, m_rxd});
    chk("R11 mod routing", {7'd0, mod_o}, {7'd0, m_mod});
    chk("R3 line_loop", {7'd0, line_loop_o}, {7'd0, lp == 2'b01});
    chk("R3 rx_band", {7'd0, rx_band_o},
        {7'd0, (lp == 2'b01) ? m_reg[0][0] : !m_reg[0][0]});
    chk("R6 line_drive", {7'd0, line_drive_o}, {7'd0, m_reg[0][1] | m_reg[3][2]});
    chk("R8 clk_pin", {7'd0, clk_pin_o}, {7'd0, exp_clk(m_reg[0], m_reg[1], xtal_i, rate16_i)});
    chk("R9 rate", {5'd0, rate_o}, {5'd0, exp_rate(m_reg[0][3:2], m_reg[0][4])});
  endtask

  // Drive at a falling edge, advance one rising edge, compare at the next falling edge.
  task automatic step(input logic cs, input logic we, input logic [2:0] a,
                      input logic [7:0] wd, input logic txd, input logic dm,
                      input logic xt, input logic r16);
    logic [7:0] nr [4];
    logic [1:0] lp;
    cs_i = cs; we_i = we; addr_i = a; wdata_i = wd;
    txd_i = txd; demod_i = dm; xtal_i = xt; rate16_i = r16;
    for (int i = 0; i < 4; i++) nr[i] = m_reg[i];
    if (cs && we) begin
      if (a == 3'd1 && wd[2]) begin
        nr[0] = 8'h00; nr[1] = 8'h00; nr[3] = 8'h00;
        nr[2] = m_reg[2] & 8'h04;
      end else if (a < 3'd4) begin
        nr[a[1:0]] = wd;
      end
    end
    lp = nr[1][1:0];
    @(posedge clk);
    @(negedge clk);
    for (int i = 0; i < 4; i++) m_reg[i] = nr[i];
    m_rxd = (lp == 2'b10) ? 1'b1 : (lp == 2'b11) ? txd : dm;
    m_mod = (lp == 2'b10) ? dm : txd;
    compare_all();
  endtask

  task automatic idle(input logic txd, input logic dm);
    step(1'b0, 1'b0, addr_i, 8'h00, txd, dm, $urandom_range(1), $urandom_range(1));
  endtask

  initial begin : wdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'h5eed_0a11));
    rst_n = 1'b0; cs_i = 0; we_i = 0; addr_i = 0; wdata_i = 0;
    txd_i = 1; demod_i = 1; xtal_i = 0; rate16_i = 1;
    for (int i = 0; i < 4; i++) m_reg[i] = 8'h00;
    m_rxd = 1'b1; m_mod = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10: reset state
    for (int a = 0; a < 8; a++) begin
      addr_i = 3'(a); #1;
      chk("R10 reset read", rdata_o, 8'h00);
    end
    chk("R10 rxd mark", {7'd0, rxd_o}, 8'h01);
    chk("R10 mod mark", {7'd0, mod_o}, 8'h01);
    chk("R10 line_loop", {7'd0, line_loop_o}, 8'h00);
    chk("R10 line_drive", {7'd0, line_drive_o}, 8'h00);
    chk("R10 clk_pin xtal", {7'd0, clk_pin_o}, {7'd0, xtal_i});
    @(negedge clk);

    // R2: normal routing with alternating data
    for (int k = 0; k < 8; k++) idle(k[0], !k[0]);

    // R11: routing switch edge carries new data at once (local)
    step(1'b1, 1'b1, 3'd1, 8'h03, 1'b0, 1'b1, 1'b0, 1'b1);
    chk("R5 first local bit", {7'd0, rxd_o}, 8'h00);
    for (int k = 0; k < 6; k++) idle(k[1], k[0]);

    // R4: remote loopback, txd toggles yet rxd stays mark
    step(1'b1, 1'b1, 3'd1, 8'h02, 1'b0, 1'b0, 1'b0, 1'b0);
    for (int k = 0; k < 6; k++) begin
      idle(k[0], k[1]);
      chk("R4 rxd held mark", {7'd0, rxd_o}, 8'h01);
      chk("R4 mod from demod", {7'd0, mod_o}, {7'd0, k[1]});
    end

    // R3/R6: analog loopback with drive sources off, then tone on
    step(1'b1, 1'b1, 3'd0, 8'h01, 1'b1, 1'b0, 1'b0, 1'b0);
    step(1'b1, 1'b1, 3'd1, 8'h01, 1'b1, 1'b0, 1'b0, 1'b0);
    chk("R6 squelched", {7'd0, line_drive_o}, 8'h00);
    chk("R3 band equals tx", {7'd0, rx_band_o}, 8'h01);
    step(1'b1, 1'b1, 3'd3, 8'h04, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R6 tone drives line", {7'd0, line_drive_o}, 8'h01);

    // R8/R9: clk16 in QAM, then in FSK
    step(1'b1, 1'b1, 3'd0, 8'h04, 1'b1, 1'b1, 1'b0, 1'b1);
    step(1'b1, 1'b1, 3'd1, 8'h08, 1'b1, 1'b1, 1'b0, 1'b1);
    chk("R8 rate16 in QAM", {7'd0, clk_pin_o}, 8'h01);
    chk("R9 QAM 2400", {5'd0, rate_o}, 8'h02);
    step(1'b1, 1'b1, 3'd0, 8'h18, 1'b1, 1'b1, 1'b0, 1'b1);
    chk("R8 FSK keeps xtal", {7'd0, clk_pin_o}, 8'h00);
    chk("R9 FSK V21", {5'd0, rate_o}, 8'h04);

    // R1: high address write ignored
    step(1'b1, 1'b1, 3'd5, 8'hff, 1'b1, 1'b1, 1'b0, 1'b1);
    chk("R1 high addr reads 0", rdata_o, 8'h00);

    // R7: soft reset keeps AUX bit 2 only
    step(1'b1, 1'b1, 3'd2, 8'hff, 1'b1, 1'b1, 1'b0, 1'b1);
    step(1'b1, 1'b1, 3'd1, 8'h0f, 1'b0, 1'b1, 1'b0, 1'b1);
    chk("R7 test cleared", rdata_o, 8'h00);
    chk("R8 xtal after srst", {7'd0, clk_pin_o}, 8'h00);
    step(1'b0, 1'b0, 3'd2, 8'h00, 1'b1, 1'b1, 1'b0, 1'b1);
    chk("R7 aux keeps bit2", rdata_o, 8'h04);

    // Constrained random mix
    for (int n = 0; n < 3000; n++) begin
      logic [2:0] a;
      logic [7:0] wd;
      a  = ($urandom_range(9) == 0) ? 3'($urandom_range(7)) : 3'($urandom_range(3));
      wd = 8'($urandom);
      if (a == 3'd1 && $urandom_range(7) != 0) wd[2] = 1'b0;
      step($urandom_range(3) == 0, $urandom_range(1), a, wd,
           $urandom_range(1), $urandom_range(1), $urandom_range(1), $urandom_range(1));
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule